// File: doc/BRIEF.md
# Two-Level Edge Interrupt Aggregator

This block collects change events from seven status inputs that run off other clocks, such as supply-presence and audio-detect comparators. Each input is synchronized, and any change of level in either direction sets a sticky flag. The flags sit in one 16-bit status word. Reading that word returns the flags and clears them.

A separate mask word, which software can read and write, gates each flag before it reaches one of two first-level interrupt lines. One line covers the three supply sources and the other covers the four audio-detect sources. Masking only hides a source from its group line: the flag still latches and still appears in the status word. An event that arrives during the cycle of a clearing read is kept, so no change is ever lost.

Top module: `irq_edge_agg`

## Requirements
- R1: Supply sources map `evt_in[6]`, `evt_in[5]` and `evt_in[4]` (USB, wall, battery) to status bits 15, 14 and 13.
- R2: Audio sources map `evt_in[3]`, `evt_in[2]`, `evt_in[1]` and `evt_in[0]` (left jack, right jack, mic short, mic present) to status bits 11, 10, 9 and 8.
- R3: Both a rising and a falling change on an input set its flag. The flag is set at the third rising clock edge after the input changes: two edges for the synchronizer and one for the flag register.
- R4: When `rd_en` is high with `addr` = 0x1F, `rdata` returns the status word in the same cycle, and every flag is cleared at the next clock edge.
- R5: If an edge is detected in the same cycle as a clearing read, that flag stays set after the read.
- R6: The mask register at `addr` = 0x27 uses bits 15:13 and 11:8, in the same positions as the status word. A 1 blocks the source and a 0 passes it. It is written with `wr_en`, reads back what was written, and resets to all zero.
- R7: `irq_ext` is the OR of the unmasked flags in status bits 15:13. `irq_codec` is the OR of the unmasked flags in status bits 11:8.
- R8: A masked source still sets its flag, and that flag is visible in a status read.
- R9: Status bits 12 and 7:0 read as zero. Writes to 0x1F have no effect. A read of any other address, and `rdata` whenever `rd_en` is low, return zero.
- R10: After reset the status word is zero, the mask is zero, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of `rd_en` |
| evt_in | input | 7 | Raw event levels, asynchronous |
| irq_ext | output | 1 | First-level supply-group interrupt |
| irq_codec | output | 1 | First-level audio-group interrupt |

## Verification
A wrong flag or mask bit shows up directly on a group interrupt line. It appears three cycles after the triggering input change, or one cycle after a mask write. A lost or stale flag shows up in the very next status read. A clear that fails to happen leaves the group line high one cycle after the read, which points to the fault at once. An event dropped during a clearing read only shows up at the following read.

// File: rtl/irq_edge_agg.sv
module irq_edge_agg #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  STAT_ADDR = 8'h1F,
  parameter logic [7:0]  MASK_ADDR = 8'h27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [6:0]        evt_in,
  output logic              irq_ext,
  output logic              irq_codec
);
  localparam int NSRC = 7;

  logic [NSRC-1:0] sync1, sync2, prev, edg, stat, mask;
  logic            stat_hit, mask_hit, clr;

  assign stat_hit = (addr == ADDR_W'(STAT_ADDR));
  assign mask_hit = (addr == ADDR_W'(MASK_ADDR));
  assign clr      = rd_en && stat_hit;
  assign edg      = sync2 ^ prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      stat  <= '0;
      mask  <= '0;
    end else begin
      sync1 <= evt_in;
      sync2 <= sync1;
      prev  <= sync2;
      stat  <= (clr ? '0 : stat) | edg;
      if (wr_en && mask_hit)
        mask <= {wdata[15:13], wdata[11:8]};
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && stat_hit)
      rdata = {stat[6:4], 1'b0, stat[3:0], 8'h00};
    else if (rd_en && mask_hit)
      rdata = {mask[6:4], 1'b0, mask[3:0], 8'h00};
  end

  assign irq_ext   = |(stat[6:4] & ~mask[6:4]);
  assign irq_codec = |(stat[3:0] & ~mask[3:0]);
endmodule

// File: rtl/irq_edge_agg_chk.sv
module irq_edge_agg_chk #(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] STAT_ADDR = 8'h1F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [15:0]       rdata,
  input logic              irq_ext,
  input logic              irq_codec,
  input logic [6:0]        stat,
  input logic [6:0]        mask,
  input logic [6:0]        edg
);
  p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edg != 0) |=> ((stat & $past(edg)) == $past(edg)));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(STAT_ADDR) && edg == 0) |=> (stat == 0));

  p_ext_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[6:4] == 3'b111) |-> !irq_ext);

  p_codec_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[3:0] == 4'hF) |-> !irq_codec);

  p_ext_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[6:4] != 0 && mask[6:4] == 0) |-> irq_ext);

  p_codec_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[3:0] != 0 && mask[3:0] == 0) |-> irq_codec);

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rdata[12] == 1'b0 && rdata[7:0] == 8'h00));

  p_stat_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == ADDR_W'(STAT_ADDR) && edg == 0) |=> $stable(stat));
endmodule

bind irq_edge_agg irq_edge_agg_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .rdata(rdata), .irq_ext(irq_ext), .irq_codec(irq_codec),
  .stat(stat), .mask(mask), .edg(edg)
);

// File: tb/irq_edge_agg_tb_top.sv
module irq_edge_agg_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0;
  logic        rd_en = 0, wr_en = 0;
  logic [15:0] wdata = 0, rdata;
  logic [6:0]  evt_in = 0;
  logic        irq_ext, irq_codec;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_edge_agg dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .evt_in(evt_in),
    .irq_ext(irq_ext), .irq_codec(irq_codec));

  // {ext, codec, toggle[6:0], mask[6:0], status word}
  localparam logic [31:0] VEC [6] = '{
    {1'b1, 1'b0, 7'b1000000, 7'b0000000, 16'h8000},
    {1'b1, 1'b0, 7'b1000000, 7'b0000000, 16'h8000},
    {1'b0, 1'b1, 7'b0001000, 7'b0000000, 16'h0800},
    {1'b1, 1'b0, 7'b0110101, 7'b0100101, 16'h6500},
    {1'b0, 1'b0, 7'b1111111, 7'b1111111, 16'hEF00},
    {1'b0, 1'b1, 7'b0000010, 7'b1110000, 16'h0200}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [15:0] word(input logic [6:0] b);
    return {b[6:4], 1'b0, b[3:0], 8'h00};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq_ext", {15'b0, irq_ext}, 16'h0);
    chk("R10 irq_codec", {15'b0, irq_codec}, 16'h0);
    rd(8'h27, d); chk("R10 mask", d, 16'h0);
    rd(8'h1F, d); chk("R10 status", d, 16'h0);

    // Table: R1 R2 R3 R7 R8
    foreach (VEC[i]) begin
      wr(8'h27, word(VEC[i][22:16]));
      @(negedge clk); evt_in = evt_in ^ VEC[i][29:23];
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk("R3 not yet set", {15'b0, irq_ext | irq_codec}, 16'h0);
      @(negedge clk);
      chk("R7 irq_ext", {15'b0, irq_ext}, {15'b0, VEC[i][31]});
      chk("R7 irq_codec", {15'b0, irq_codec}, {15'b0, VEC[i][30]});
      rd(8'h1F, d); chk("R1 R2 R8 status", d, VEC[i][15:0]);
      chk("R4 cleared irq", {15'b0, irq_ext | irq_codec}, 16'h0);
      rd(8'h1F, d); chk("R4 cleared status", d, 16'h0);
    end

    // R6 mask readback
    wr(8'h27, 16'hFFFF);
    rd(8'h27, d); chk("R6 mask readback", d, 16'hEF00);
    wr(8'h27, 16'h0000);
    rd(8'h27, d); chk("R6 mask cleared", d, 16'h0000);

    // R9 status write ignored, unused and other addresses
    wr(8'h1F, 16'hFFFF);
    chk("R9 write no irq", {15'b0, irq_ext | irq_codec}, 16'h0);
    rd(8'h1F, d); chk("R9 status write ignored", d, 16'h0);
    rd(8'h20, d); chk("R9 other addr", d, 16'h0);
    @(negedge clk); #1 chk("R9 idle rdata", rdata, 16'h0);

    // R5 edge coincident with clearing read
    @(negedge clk); evt_in = evt_in ^ 7'b0000100;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h1F; rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk("R5 irq kept", {15'b0, irq_codec}, 16'h1);
    rd(8'h1F, d); chk("R5 flag kept", d, 16'h0400);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule